// File: doc/BRIEF.md
# Integer ALU with Dual-Width Condition Codes

This block is a single-cycle 64-bit integer arithmetic unit for a processor execute stage. It takes two operands, a 4-bit opcode, an incoming carry flag and a flag-update enable. It returns the result in the same cycle. It supports plain, carry-chained and tagged add and subtract, plus four logical operations.

From every result the block derives two condition-code nibbles. A narrow set is computed on the low 32 bits and a wide set on all 64 bits. Both sets are registered on the rising clock edge when the update enable is high.

Tagged arithmetic treats nonzero low two bits in either operand as a tag fault. Depending on the opcode, the fault either marks overflow in the narrow set or raises a trap request. The trap request is combinational with the result, so it is a one-cycle strobe for the operation presented.

Top module: `alu_cc`

## Requirements
- R1: A synchronous active-low reset clears both flag nibbles to 4'b0000. Each nibble is packed N at bit 3, Z at bit 2, V at bit 1 and C at bit 0.
- R2: When flagEn is low, the result and trap outputs are still produced, and both flag nibbles keep their previous values across the clock edge.
- R3: On an update, all old flag bits are discarded. In the new values, Z is set when the result is zero and N is set when the result's top bit is one. Both are judged on bits 31:0 for ccNarrow and on bits 63:0 for ccWide.
- R4: Opcode 0 (add) returns a+b and ignores carryIn. C is the carry out of the lane, and V is the lane's top bit of (a XNOR b) & (a ^ result).
- R5: Opcode 1 (add with carry) returns a+b+carryIn. C is the carry out of the whole three-input sum, and V uses the same rule as R4.
- R6: Opcode 2 (subtract) returns a-b and ignores carryIn. C is set when a is unsigned-less-than b in the lane, and V is the lane's top bit of (a ^ b) & (a ^ result).
- R7: Opcode 3 (subtract with borrow) returns a-b-carryIn. C is the borrow of the whole subtraction, and V uses the same rule as R6.
- R8: Opcodes 4 (tagged add) and 5 (tagged subtract) behave as R4 and R6 without carryIn. In addition, ccNarrow V is set when (a|b)&2'b11 is nonzero. ccWide V uses only the arithmetic overflow.
- R9: Opcodes 6 (trapping tagged add) and 7 (trapping tagged subtract) compute the result and the N, Z and C flags as in R8, but V is cleared in both nibbles.
- R10: Opcodes 8 (AND), 9 (OR), 10 (XOR) and 11 to 15 (pass b) produce the logical result. They set N and Z from it and clear C and V in both nibbles.
- R11: tagTrap is high in the same cycle only for opcodes 6 and 7. With those opcodes it is high when the operand tag bits are nonzero, or when either lane overflows arithmetically. It is low for every other opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rstN | input | 1 | Synchronous active-low reset of the flag registers |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| opCode | input | 4 | Operation select (encodings in R4 to R10) |
| carryIn | input | 1 | Incoming carry/borrow for opcodes 1 and 3 |
| flagEn | input | 1 | Load the new flags at the next rising edge |
| result | output | 64 | Combinational operation result |
| ccNarrow | output | 4 | Registered 32-bit flags {N,Z,V,C} |
| ccWide | output | 4 | Registered 64-bit flags {N,Z,V,C} |
| tagTrap | output | 1 | Combinational tag-overflow trap request |

## Verification
The result and tagTrap depend only on the inputs of the current cycle. The bench drives operands at a falling edge and samples these two outputs one nanosecond later, within the same cycle. The flag nibbles pass through one register, so they are due after the next rising edge. The bench reads them at the falling edge that follows, before it changes any input. The hold and reset cases use the same spacing, so each comparison sees exactly one clock edge's effect.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  localparam int CC_N = 3;
  localparam int CC_Z = 2;
  localparam int CC_V = 1;
  localparam int CC_C = 0;
  localparam int TAG_W = 2;

  typedef enum logic [1:0] {
    LG_AND  = 2'd0,
    LG_OR   = 2'd1,
    LG_XOR  = 2'd2,
    LG_PASS = 2'd3
  } logicSel_e;

  // strobes from decode to the datapath
  typedef struct packed {
    logic      isSub;
    logic      useCarry;
    logic      isTagged;
    logic      trapOnTag;
    logic      isLogic;
    logicSel_e logicSel;
  } aluCtl_t;

endpackage

// File: rtl/alu_cc_ctrl.sv
module alu_cc_ctrl
  import alu_cc_pkg::*;
(
  input  logic [3:0] opCode,
  output aluCtl_t    ctl
);

  always_comb begin
    ctl = '0;
    if (opCode[3]) begin
      ctl.isLogic  = 1'b1;
      ctl.logicSel = opCode[2] ? LG_PASS : logicSel_e'(opCode[1:0]);
    end else if (opCode[2]) begin
      ctl.isTagged  = 1'b1;
      ctl.isSub     = opCode[0];
      ctl.trapOnTag = opCode[1];
    end else begin
      ctl.isSub    = opCode[1];
      ctl.useCarry = opCode[0];
    end
  end

endmodule

// File: rtl/alu_cc_flags.sv
module alu_cc_flags
  import alu_cc_pkg::*;
#(
  parameter int W       = 64,
  parameter bit TAG_OVF = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         carryIn,
  input  aluCtl_t      ctl,
  input  logic         tagBad,
  output logic [W-1:0] res,
  output logic [3:0]   cc,
  output logic         arithOvf
);

  logic [W:0]   sum;
  logic [W-1:0] bEff;
  logic [W-1:0] logicRes;
  logic         cinEff;
  logic         carryRaw;
  logic         vRaw;

  always_comb begin
    cinEff = ctl.useCarry & carryIn;
    bEff   = ctl.isSub ? ~b : b;
    sum    = {1'b0, a} + {1'b0, bEff} + {{W{1'b0}}, ctl.isSub ^ cinEff};

    case (ctl.logicSel)
      LG_AND:  logicRes = a & b;
      LG_OR:   logicRes = a | b;
      LG_XOR:  logicRes = a ^ b;
      default: logicRes = b;
    endcase

    res      = ctl.isLogic ? logicRes : sum[W-1:0];
    carryRaw = sum[W] ^ ctl.isSub;
    vRaw     = ctl.isSub ? ((a[W-1] ^ b[W-1]) & (a[W-1] ^ sum[W-1]))
                         : (~(a[W-1] ^ b[W-1]) & (a[W-1] ^ sum[W-1]));
    arithOvf = ~ctl.isLogic & vRaw;

    cc       = '0;
    cc[CC_N] = res[W-1];
    cc[CC_Z] = (res == '0);
    cc[CC_C] = ~ctl.isLogic & carryRaw;
    cc[CC_V] = ~ctl.isLogic & ~ctl.trapOnTag &
               (vRaw | (TAG_OVF & ctl.isTagged & tagBad));
  end

endmodule

// File: rtl/alu_cc_dpath.sv
module alu_cc_dpath
  import alu_cc_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              flagEn,
  input  aluCtl_t           ctl,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        ccNarrow,
  output logic [3:0]        ccWide,
  output logic              tagTrap
);

  localparam int LANES = 2;

  logic              tagBad;
  logic [DATA_W-1:0] resBy  [LANES];
  logic [3:0]        ccNext [LANES];
  logic              ovfBy  [LANES];

  assign tagBad = |(opA[TAG_W-1:0] | opB[TAG_W-1:0]);

  // lane 0: narrow flags with tag overflow, lane 1: full width
  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam int LW = (g == 0) ? NARROW_W : DATA_W;
    logic [LW-1:0] laneRes;

    alu_cc_flags #(
      .W       (LW),
      .TAG_OVF (g == 0)
    ) u_flags (
      .a        (opA[LW-1:0]),
      .b        (opB[LW-1:0]),
      .carryIn  (carryIn),
      .ctl      (ctl),
      .tagBad   (tagBad),
      .res      (laneRes),
      .cc       (ccNext[g]),
      .arithOvf (ovfBy[g])
    );

    assign resBy[g] = DATA_W'(laneRes);
  end

  assign result  = resBy[LANES-1];
  assign tagTrap = ctl.trapOnTag & (tagBad | ovfBy[0] | ovfBy[1]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ccNarrow <= '0;
      ccWide   <= '0;
    end else if (flagEn) begin
      ccNarrow <= ccNext[0];
      ccWide   <= ccNext[1];
    end
  end

  a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !flagEn |=> ($stable(ccNarrow) && $stable(ccWide)));

  a_r9_trap_no_v: assert property (@(posedge clk) disable iff (!rstN)
    (flagEn && tagTrap) |=> (!ccNarrow[CC_V] && !ccWide[CC_V]));

  a_r10_logic_clear_cv: assert property (@(posedge clk) disable iff (!rstN)
    (flagEn && ctl.isLogic) |=> (ccNarrow[1:0] == 2'b00 && ccWide[1:0] == 2'b00));

  a_r3_zero_lanes: assert property (@(posedge clk) disable iff (!rstN)
    flagEn |=> (!ccWide[CC_Z] || ccNarrow[CC_Z]));

  a_r3_lanes_agree: assert property (@(posedge clk) disable iff (!rstN)
    resBy[0][NARROW_W-1:0] == result[NARROW_W-1:0]);

  a_r11_trap_source: assert property (@(posedge clk) disable iff (!rstN)
    tagTrap |-> ctl.trapOnTag);

endmodule

// File: rtl/alu_cc.sv
module alu_cc
  import alu_cc_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int OP_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [OP_W-1:0]   opCode,
  input  logic              carryIn,
  input  logic              flagEn,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        ccNarrow,
  output logic [3:0]        ccWide,
  output logic              tagTrap
);

  aluCtl_t ctl;

  alu_cc_ctrl u_ctrl (
    .opCode (opCode[3:0]),
    .ctl    (ctl)
  );

  alu_cc_dpath #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .flagEn   (flagEn),
    .ctl      (ctl),
    .result   (result),
    .ccNarrow (ccNarrow),
    .ccWide   (ccWide),
    .tagTrap  (tagTrap)
  );

endmodule

// File: tb/alu_cc_tb.sv
`timescale 1ns/1ps
module alu_cc_tb;

  typedef struct packed {
    logic [3:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic        cin;
    logic [63:0] res;
    logic [3:0]  nar;
    logic [3:0]  wid;
    logic        trap;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  64'h1, 64'h2, 1'b1, 64'h3, 4'h0, 4'h0, 1'b0},                       // R4/R5 carryIn ignored
    '{4'd0,  64'h0000_0000_FFFF_FFFF, 64'h1, 1'b0, 64'h0000_0001_0000_0000, 4'h5, 4'h0, 1'b0},
    '{4'd0,  64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 64'h8000_0000_0000_0000, 4'h5, 4'hA, 1'b0},
    '{4'd0,  64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 64'h0, 4'h5, 4'h5, 1'b0},
    '{4'd1,  64'h5, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'h5, 4'h1, 4'h1, 1'b0},      // R5
    '{4'd2,  64'h3, 64'h5, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 4'h9, 4'h9, 1'b0},      // R6
    '{4'd2,  64'h8000_0000, 64'h1, 1'b0, 64'h7FFF_FFFF, 4'h2, 4'h0, 1'b0},
    '{4'd3,  64'h5, 64'h5, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 4'h9, 4'h9, 1'b0},      // R7
    '{4'd8,  64'hF0, 64'h3C, 1'b1, 64'h30, 4'h0, 4'h0, 1'b0},                     // R10 after C set
    '{4'd3,  64'h5, 64'h4, 1'b1, 64'h0, 4'h4, 4'h4, 1'b0},
    '{4'd4,  64'h1, 64'h4, 1'b0, 64'h5, 4'h2, 4'h0, 1'b0},                        // R8 tag
    '{4'd4,  64'h4, 64'h8, 1'b0, 64'hC, 4'h0, 4'h0, 1'b0},
    '{4'd6,  64'h4, 64'h7FFF_FFFC, 1'b0, 64'h8000_0000, 4'h8, 4'h0, 1'b1},        // R9 ovf
    '{4'd6,  64'h2, 64'h4, 1'b0, 64'h6, 4'h0, 4'h0, 1'b1},                        // R9 tag
    '{4'd5,  64'h8, 64'hC, 1'b0, 64'hFFFF_FFFF_FFFF_FFFC, 4'h9, 4'h9, 1'b0},
    '{4'd7,  64'h4, 64'h4, 1'b0, 64'h0, 4'h4, 4'h4, 1'b0},
    '{4'd9,  64'h8000_0000_0000_0000, 64'h0, 1'b0, 64'h8000_0000_0000_0000, 4'h4, 4'h8, 1'b0},
    '{4'd10, 64'h1234, 64'h1234, 1'b0, 64'h0, 4'h4, 4'h4, 1'b0},
    '{4'd11, 64'h55, 64'hFFFF_FFFF_0000_0000, 1'b0, 64'hFFFF_FFFF_0000_0000, 4'h4, 4'h8, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [3:0]  opCode = '0;
  logic        carryIn = 1'b0;
  logic        flagEn = 1'b0;
  logic [63:0] result;
  logic [3:0]  ccNarrow;
  logic [3:0]  ccWide;
  logic        tagTrap;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_cc u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .opA      (opA),
    .opB      (opB),
    .opCode   (opCode),
    .carryIn  (carryIn),
    .flagEn   (flagEn),
    .result   (result),
    .ccNarrow (ccNarrow),
    .ccWide   (ccWide),
    .tagTrap  (tagTrap)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0:       return "R4";
      4'd1:       return "R5";
      4'd2:       return "R6";
      4'd3:       return "R7";
      4'd4, 4'd5: return "R8";
      4'd6, 4'd7: return "R9";
      default:    return "R10";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ccNarrow", 64'(ccNarrow), 64'h0);
    check("R1 reset ccWide", 64'(ccWide), 64'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      opCode  = VECS[i].op;
      opA     = VECS[i].a;
      opB     = VECS[i].b;
      carryIn = VECS[i].cin;
      flagEn  = 1'b1;
      #1;
      check({reqOf(VECS[i].op), " result"}, result, VECS[i].res);
      check("R11 tagTrap", 64'(tagTrap), 64'(VECS[i].trap));
      @(negedge clk);
      check({"R3 ", reqOf(VECS[i].op), " ccNarrow"}, 64'(ccNarrow), 64'(VECS[i].nar));
      check({"R3 ", reqOf(VECS[i].op), " ccWide"}, 64'(ccWide), 64'(VECS[i].wid));
      flagEn = 1'b0;
    end

    // R2: flags held while the result still updates
    opCode = 4'd2; opA = 64'h3; opB = 64'h5; carryIn = 1'b0; flagEn = 1'b0;
    #1;
    check("R2 result with flagEn low", result, 64'hFFFF_FFFF_FFFF_FFFE);
    @(negedge clk);
    check("R2 ccNarrow held", 64'(ccNarrow), 64'h4);
    check("R2 ccWide held", 64'(ccWide), 64'h8);

    // R1: mid-run synchronous reset clears nonzero flags
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1 mid reset ccNarrow", 64'(ccNarrow), 64'h0);
    check("R1 mid reset ccWide", 64'(ccWide), 64'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule